// File: doc/BRIEF.md
# Chained Timer Pair with Hardware Trigger Start

This block contains two up-counting timers driven by one internal clock. The first timer, the master, counts only after software sets its run bit. Each timer has a prescaler that divides the clock. The master counts up to its period value, wraps to zero and produces an update event at that moment. A mode field decides whether this event is driven onto the trigger output.

The second timer, the slave, has a trigger-mode controller. When it sees a rising edge on its selected trigger, it sets its own run bit in hardware and raises a sticky status flag. It then counts on from whatever value its counter already holds, which software may have loaded beforehand. It keeps running until software clears the run bit.

Software reaches all fields through a simple write port and a combinational read port. Period and prescaler values take effect through shadow copies at the next update event.

Top module: `tmr_link_top`

## Requirements
- R1: After reset, every register reads 0, except both period registers (addresses 2 and 8 in the map below), which read 0xFFFF. The trigger output is 0.
- R2: Register map, by word address: 0 master control (bit0 run, bits[6:4] trigger-output mode), 1 master prescaler, 2 master period, 3 master counter, 4 slave control (bit0 run), 5 slave mode (bits[2:0] slave mode, bits[8:4] trigger select), 6 slave prescaler, 7 slave counter, 8 slave period, 9 slave status (bit0 trigger flag). A timer counts only while its run bit is 1. With prescaler value P, the counter advances once every P+1 clocks. The first advance comes P+1 clocks after the run bit is set, because the divider is cleared while the timer is stopped.
- R3: After reaching its period value, a counter wraps to 0 at the next advance, which is the update event. With master mode code 3'b010, the trigger output is high for exactly the one clock in which the master counter first shows 0. Any other mode code keeps the trigger output low.
- R4: Prescaler and period values written while a timer runs take effect only after its next update event. Values written while it is stopped take effect at once.
- R5: With trigger select 5'b00000 (the master's trigger output) and slave mode 3'b110, a rising trigger edge sets the slave run bit. The run bit reads 1 two clocks after the trigger output rises. Any other select or mode code leaves the run bit unchanged.
- R6: When the trigger starts the slave, its counter is not reset. It counts on from its present value.
- R7: Once running, the slave keeps counting until software writes 0 to its run bit. A later trigger neither stops it nor disturbs its count.
- R8: The slave trigger flag is set together with the hardware run bit. Writing 0 to it clears it, and writing 1 leaves it unchanged. If a clearing write and a trigger fall in the same clock, the flag stays set.
- R9: A write to a counter address loads that counter with the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock shared by both timers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Combinational read data for rd_addr |
| trgo | output | 1 | Master trigger output pulse |

## Verification
A wrong prescaler or shadow state shows up within a single prescaled period as a counter value that reads one step early or late. A bad wrap shows as a trigger pulse in the wrong cycle or a pulse longer than one clock. A fault in the edge detector or slave mode decode shows at the slave run bit or flag within two clocks of the master's trigger pulse. Resetting or stopping the slave wrongly shows up in the slave counter readback within one slave prescaled period.

// File: rtl/tmr_link_pkg.sv
package tmr_link_pkg;
    localparam int ADDR_W  = 4;
    localparam int MMS_W   = 3;
    localparam int SMS_W   = 3;
    localparam int TS_W    = 5;
    localparam int MMS_LSB = 4;
    localparam int SMS_LSB = 0;
    localparam int TS_LSB  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_M_CTRL = 4'd0,
        REG_M_PSC  = 4'd1,
        REG_M_ARR  = 4'd2,
        REG_M_CNT  = 4'd3,
        REG_S_CTRL = 4'd4,
        REG_S_MODE = 4'd5,
        REG_S_PSC  = 4'd6,
        REG_S_CNT  = 4'd7,
        REG_S_ARR  = 4'd8,
        REG_S_STAT = 4'd9
    } reg_addr_e;

    localparam logic [MMS_W-1:0] MMS_UPDATE  = 3'b010;
    localparam logic [SMS_W-1:0] SMS_TRIGGER = 3'b110;
    localparam logic [TS_W-1:0]  TS_MASTER   = 5'b00000;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] psc_pre,
    input  logic [W-1:0] arr_pre,
    output logic [W-1:0] cnt,
    output logic         update
);
    typedef struct packed {
        logic [W-1:0] div;
        logic [W-1:0] psc_sh;
        logic [W-1:0] arr_sh;
        logic [W-1:0] cnt;
        logic         upd;
    } core_t;

    core_t s_d, s_q;
    logic  tick;
    logic  wrap;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        tick    = 1'b0;
        if (!en) begin
            s_d.div = '0;
        end else if (s_q.div == s_q.psc_sh) begin
            s_d.div = '0;
            tick    = 1'b1;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
        wrap = tick && (s_q.cnt == s_q.arr_sh);
        if (cnt_wr) begin
            s_d.cnt = cnt_wdata;
        end else if (tick) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
        if ((wrap && !cnt_wr) || !en) begin
            s_d.psc_sh = psc_pre;
            s_d.arr_sh = arr_pre;
        end
        if (wrap && !cnt_wr) begin
            s_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.arr_sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt    = s_q.cnt;
    assign update = s_q.upd;

    AST_UPDATE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd |-> (s_q.cnt == '0)); // R3
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(s_q.cnt)); // R2
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_wr && (s_q.cnt != s_q.arr_sh)) |=>
        ((s_q.cnt == $past(s_q.cnt)) || (s_q.cnt == W'($past(s_q.cnt) + 1'b1)))); // R2
endmodule

// File: rtl/tmr_trig_detect.sv
module tmr_trig_detect import tmr_link_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_master,
    input  logic [TS_W-1:0]  sel,
    input  logic [SMS_W-1:0] mode,
    output logic             hit
);
    typedef struct packed {
        logic sync;
        logic prev;
    } det_t;

    det_t d_d, d_q;
    logic trig_sel;

    always_comb begin
        trig_sel  = (sel == TS_MASTER) ? trig_master : 1'b0;
        d_d.sync  = trig_sel;
        d_d.prev  = d_q.sync;
        hit       = d_q.sync && !d_q.prev && (mode == SMS_TRIGGER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    AST_HIT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (mode == SMS_TRIGGER)); // R5
endmodule

// File: rtl/tmr_link_top.sv
module tmr_link_top import tmr_link_pkg::*; #(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              trgo
);
    typedef struct packed {
        logic             m_en;
        logic [MMS_W-1:0] m_mms;
        logic [W-1:0]     m_psc;
        logic [W-1:0]     m_arr;
        logic             s_en;
        logic [SMS_W-1:0] s_sms;
        logic [TS_W-1:0]  s_ts;
        logic [W-1:0]     s_psc;
        logic [W-1:0]     s_arr;
        logic             s_tif;
    } regs_t;

    regs_t r_d, r_q;
    logic [W-1:0] m_cnt, s_cnt;
    logic         m_upd, s_upd;
    logic         m_cnt_wr, s_cnt_wr;
    logic         hit;
    logic         flag_clr;

    assign m_cnt_wr = wr_en && (wr_addr == REG_M_CNT);
    assign s_cnt_wr = wr_en && (wr_addr == REG_S_CNT);
    assign flag_clr = wr_en && (wr_addr == REG_S_STAT) && !wr_data[0];
    assign trgo     = m_upd && (r_q.m_mms == MMS_UPDATE);

    tmr_count_core #(.W(W)) u_master (
        .clk(clk), .rst_n(rst_n), .en(r_q.m_en),
        .cnt_wr(m_cnt_wr), .cnt_wdata(wr_data),
        .psc_pre(r_q.m_psc), .arr_pre(r_q.m_arr),
        .cnt(m_cnt), .update(m_upd)
    );

    tmr_count_core #(.W(W)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(r_q.s_en),
        .cnt_wr(s_cnt_wr), .cnt_wdata(wr_data),
        .psc_pre(r_q.s_psc), .arr_pre(r_q.s_arr),
        .cnt(s_cnt), .update(s_upd)
    );

    tmr_trig_detect u_det (
        .clk(clk), .rst_n(rst_n), .trig_master(trgo),
        .sel(r_q.s_ts), .mode(r_q.s_sms), .hit(hit)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                REG_M_CTRL: begin
                    r_d.m_en  = wr_data[0];
                    r_d.m_mms = wr_data[MMS_LSB +: MMS_W];
                end
                REG_M_PSC:  r_d.m_psc = wr_data;
                REG_M_ARR:  r_d.m_arr = wr_data;
                REG_S_CTRL: r_d.s_en  = wr_data[0];
                REG_S_MODE: begin
                    r_d.s_sms = wr_data[SMS_LSB +: SMS_W];
                    r_d.s_ts  = wr_data[TS_LSB +: TS_W];
                end
                REG_S_PSC:  r_d.s_psc = wr_data;
                REG_S_ARR:  r_d.s_arr = wr_data;
                default: ;
            endcase
        end
        if (flag_clr) r_d.s_tif = 1'b0;
        if (hit) begin
            r_d.s_en  = 1'b1;
            r_d.s_tif = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.m_arr <= '1;
            r_q.s_arr <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_M_CTRL: begin
                rd_data[0]                 = r_q.m_en;
                rd_data[MMS_LSB +: MMS_W]  = r_q.m_mms;
            end
            REG_M_PSC:  rd_data = r_q.m_psc;
            REG_M_ARR:  rd_data = r_q.m_arr;
            REG_M_CNT:  rd_data = m_cnt;
            REG_S_CTRL: rd_data[0] = r_q.s_en;
            REG_S_MODE: begin
                rd_data[SMS_LSB +: SMS_W]  = r_q.s_sms;
                rd_data[TS_LSB +: TS_W]    = r_q.s_ts;
            end
            REG_S_PSC:  rd_data = r_q.s_psc;
            REG_S_CNT:  rd_data = s_cnt;
            REG_S_ARR:  rd_data = r_q.s_arr;
            REG_S_STAT: rd_data[0] = r_q.s_tif;
            default:    rd_data = '0;
        endcase
    end

    AST_TRIG_STARTS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> r_q.s_en); // R5
    AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> r_q.s_tif); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.s_tif && !flag_clr) |=> r_q.s_tif); // R8
    AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.s_en && !(wr_en && (wr_addr == REG_S_CTRL))) |=> r_q.s_en); // R7
    AST_SLAVE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_upd |-> (s_cnt == '0)); // R3
    AST_TRGO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trgo && (r_q.m_arr != '0)) |=> !trgo); // R3
endmodule

// File: tb/sim_tmr_link_top.sv
module sim_tmr_link_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trgo;
    int checks = 0;
    int fails = 0;

    localparam logic [3:0] A_MCTRL = 4'd0, A_MPSC = 4'd1, A_MARR = 4'd2, A_MCNT = 4'd3,
                           A_SCTRL = 4'd4, A_SMODE = 4'd5, A_SPSC = 4'd6, A_SCNT = 4'd7,
                           A_SARR = 4'd8, A_SSTAT = 4'd9;

    tmr_link_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .trgo(trgo)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 10; a++) begin
            peek(4'(a), v);
            chk("R1 reset value", v, (a == 2 || a == 8) ? 16'hFFFF : 16'h0000);
        end
        chk("R1 trgo at reset", {15'd0, trgo}, 16'd0);
    endtask

    task automatic t_master;
        logic [15:0] v;
        wr(A_MPSC, 16'd2);
        wr(A_MARR, 16'd3);
        repeat (5) @(negedge clk);
        peek(A_MCNT, v);
        chk("R2 stopped master holds", v, 16'd0);
        wr(A_MCTRL, 16'h0021);
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk);
            peek(A_MCNT, v);
            chk("R2 prescaled count", v, 16'((n / 3) % 4));
            chk("R3 trigger pulse", {15'd0, trgo}, (n % 12 == 0) ? 16'd1 : 16'd0);
        end
        wr(A_MCTRL, 16'h0000);
    endtask

    task automatic t_slave_start;
        logic [15:0] en, sc, fl;
        wr(A_MCNT, 16'd0);
        wr(A_SPSC, 16'd2);
        wr(A_SCNT, 16'h0040);
        wr(A_SMODE, 16'h0006);
        wr(A_MCTRL, 16'h0021);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            peek(A_SCTRL, en);
            peek(A_SCNT, sc);
            peek(A_SSTAT, fl);
            if (n == 12 || n == 24) chk("R3 master update pulse", {15'd0, trgo}, 16'd1);
            if (n < 14) begin
                chk("R5 slave still stopped", en, 16'd0);
                if (n == 13) begin
                    chk("R9 preloaded slave counter", sc, 16'h0040);
                    chk("R8 flag clear before trigger", fl, 16'd0);
                    wr_en = 1'b1; wr_addr = A_SSTAT; wr_data = 16'h0000;
                end
            end else begin
                chk("R7 slave run bit held", en, 16'd1);
                chk("R6 count resumes from preload", sc, 16'(16'h0040 + (n - 14) / 3));
                if (n == 14) begin
                    chk("R8 trigger wins over clear", fl, 16'd1);
                    wr_en = 1'b0;
                end
            end
        end
    endtask

    task automatic t_flag_and_stop;
        logic [15:0] v, held;
        wr(A_SSTAT, 16'h0001);
        peek(A_SSTAT, v);
        chk("R8 write one keeps flag", v, 16'd1);
        wr(A_SSTAT, 16'h0000);
        peek(A_SSTAT, v);
        chk("R8 write zero clears flag", v, 16'd0);
        wr(A_MCTRL, 16'h0001);
        wr(A_SCTRL, 16'h0000);
        peek(A_SCNT, held);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            chk("R3 trgo low for other mode", {15'd0, trgo}, 16'd0);
            if (n % 10 == 0) begin
                peek(A_SCNT, v);
                chk("R7 slave stopped by software", v, held);
                peek(A_SCTRL, v);
                chk("R7 slave run bit stays cleared", v, 16'd0);
            end
        end
    endtask

    task automatic t_ignored_modes;
        logic [15:0] v;
        int pulses;
        pulses = 0;
        wr(A_SMODE, 16'h0016);
        wr(A_MCTRL, 16'h0021);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (trgo) pulses++;
        end
        peek(A_SCTRL, v);
        chk("R5 other select ignored", v, 16'd0);
        peek(A_SSTAT, v);
        chk("R5 other select no flag", v, 16'd0);
        wr(A_SMODE, 16'h0000);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (trgo) pulses++;
        end
        peek(A_SCTRL, v);
        chk("R5 other mode ignored", v, 16'd0);
        chk("R3 master pulses seen", 16'(pulses >= 4), 16'd1);
        wr(A_MCTRL, 16'h0000);
    endtask

    task automatic t_shadow;
        logic [15:0] v;
        logic [15:0] exp_seq [10] = '{16'd1, 16'd2, 16'd3, 16'd0, 16'd1,
                                      16'd2, 16'd3, 16'd4, 16'd5, 16'd0};
        wr(A_MCNT, 16'd0);
        wr(A_MPSC, 16'd0);
        wr(A_MARR, 16'd3);
        wr(A_MCTRL, 16'h0001);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            peek(A_MCNT, v);
            chk("R4 period via shadow", v, exp_seq[n-1]);
            if (n == 1) begin
                wr_en = 1'b1; wr_addr = A_MARR; wr_data = 16'd5;
            end else if (n == 2) begin
                wr_en = 1'b0;
            end
        end
        wr(A_MCTRL, 16'h0000);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master();
        t_slave_start();
        t_flag_and_stop();
        t_ignored_modes();
        t_shadow();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule